// File: doc/BRIEF.md
# Trigger Event Timestamp Queue

This block stamps asynchronous trigger pulses with the running 64-bit time. It has two trigger pins. Each pin is first brought into the clock domain and then checked for its chosen active edge. Every active edge stores the value of `cur_time` in a 16-entry queue that belongs to that pin. Software or a downstream engine empties each queue through a valid/ready stream of 32-bit words. Every timestamp goes out as two words: the lower half first, then the upper half.

Each queue drives three event lines, and each line has its own enable input. The first says a stamp is waiting. The second says the fill level has reached a shared threshold. The third says an edge was lost because the queue was full. The threshold is written through a 5-bit port, and any value above 15 is refused. A set overflow flag stays set until a clear pulse for that pin arrives.

Stream rules for each pin: `ts_valid` is high whenever the queue holds a stamp, and `ts_half` tells which half `ts_data` currently shows. A word is taken on a clock edge where both valid and ready are high. Ready may stay high with no penalty. Taking the upper half removes the stamp. Ready asserted while valid is low does nothing.

Top module: `ext_ts_capture_fifo`

## Requirements
- R1: A level change on `trig_in[c]` that forms an active edge stores the value `cur_time` holds at the third rising clock edge after the change. The status reflects the new stamp after that clock edge.
- R2: `trig_fall_sel[c]`=0 selects rising edges and 1 selects falling edges. Edges of the other direction store nothing.
- R3: Each queue holds up to 16 stamps and returns them oldest first.
- R4: Each stamp is read as two stream words. The word shown with `ts_half[c]`=0 is bits 31:0, and the word shown with `ts_half[c]`=1 is bits 63:32. A handshake on the upper word removes the stamp and returns `ts_half[c]` to 0.
- R5: `ts_valid[c]` is 1 exactly while queue c is not empty. Bit 0 belongs to trigger 0 and bit 1 to trigger 1.
- R6: Asserting `ts_ready[c]` while `ts_valid[c]` is 0 changes neither the queue nor `ts_half[c]`.
- R7: An edge that arrives while queue c holds 16 stamps is discarded, even if a stamp is removed in the same cycle. It sets a sticky overflow flag for that pin. `ovf_clr[c]` clears the flag, and a new overflow in the same cycle takes priority over the clear.
- R8: The threshold event for pin c is raised while the fill level of queue c is greater than or equal to the programmed threshold.
- R9: A write on `thr_wr` loads `thr_wdata` as the threshold only when the value is 15 or less. A larger value leaves the old threshold in place.
- R10: `evt_avail[c]`, `evt_thr[c]` and `evt_ovf[c]` each show their condition ANDed with their own enable bit (`avail_en[c]`, `thr_en[c]`, `ovf_en[c]`).
- R11: After reset both queues are empty, `ts_half` is 0, both overflow flags are clear and the threshold is 8.
- R12: The two pins share no state other than the threshold value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cur_time | input | 64 | Running time value to stamp |
| trig_in | input | 2 | Asynchronous trigger pins |
| trig_fall_sel | input | 2 | Per-pin edge select, 1 = falling |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 5 | Threshold write value |
| ts_valid | output | 2 | Per-pin stream valid (queue not empty) |
| ts_ready | input | 2 | Per-pin stream ready |
| ts_half | output | 2 | Per-pin half select of current word, 1 = upper |
| ts_data | output | 64 | Pin 0 word in 31:0, pin 1 word in 63:32 |
| ovf_clr | input | 2 | Per-pin overflow flag clear |
| avail_en | input | 2 | Stamp-waiting event enables |
| thr_en | input | 2 | Threshold event enables |
| ovf_en | input | 2 | Overflow event enables |
| evt_avail | output | 2 | Stamp-waiting events |
| evt_thr | output | 2 | Threshold-reached events |
| evt_ovf | output | 2 | Overflow events |

## Verification
Some properties are checked on every cycle by assertions. The fill count never goes above the queue depth. An upper-word handshake with no push lowers the count by one. The half select is never 1 while the queue is empty. An overflow sets the flag, and the flag stays set until it is cleared. A refused threshold write leaves the threshold unchanged. An active edge pulse never lasts two cycles in a row.

Other behaviours can only be shown by the bench's scenarios, because they need a reference model over time. These are the exact cycle a stamp is captured, the oldest-first order of stamps, the word sequence of each stamp, dropped edges on a full queue, and the way the enables gate the events.

// File: rtl/ettc_pkg.sv
package ettc_pkg;
  localparam int unsigned TS_W   = 64;
  localparam int unsigned HALF_W = TS_W / 2;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/ettc_edge_detect.sv
module ettc_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trig_async};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level    = sync_q[SYNC_STAGES-1];
  assign edge_hit = fall_sel ? (!level && last_q) : (level && !last_q);

  // R2: one level change yields a single-cycle pulse
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (!edge_hit || (fall_sel != $past(fall_sel))));
endmodule

// File: rtl/ettc_ts_fifo.sv
module ettc_ts_fifo
  import ettc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TS_W-1:0]   push_ts,
  input  logic              rd_ready,
  input  logic              ovf_clr,
  input  logic [THR_W-1:0]  thr,
  output logic              rd_valid,
  output logic              rd_half,
  output logic [HALF_W-1:0] rd_data,
  output logic              thr_hit,
  output logic              ovf_flag
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [TS_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  half_e            half_q;
  logic             ovf_q;
  logic             full, do_push, do_pop, hs;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign hs      = rd_ready && rd_valid;
  assign do_pop  = hs && (half_q == HALF_HI);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_ts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      half_q <= HALF_LO;
      ovf_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (hs) half_q <= (half_q == HALF_LO) ? HALF_HI : HALF_LO;
      if (push && full)  ovf_q <= 1'b1;
      else if (ovf_clr)  ovf_q <= 1'b0;
    end
  end

  assign rd_valid = (count != '0);
  assign rd_half  = half_q;
  assign rd_data  = (half_q == HALF_HI) ? mem[rd_ptr][TS_W-1:HALF_W]
                                        : mem[rd_ptr][HALF_W-1:0];
  assign thr_hit  = (count >= CNT_W'(thr));
  assign ovf_flag = ovf_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_pop_drops_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count == $past(count) - 1'b1));
  assert_half_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_q == HALF_HI && count == '0));
  assert_drop_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf_q);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/ext_ts_capture_fifo.sv
module ext_ts_capture_fifo
  import ettc_pkg::*;
#(
  parameter int unsigned NUM_TRIG    = 2,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned THR_W       = 4,
  parameter int unsigned THR_RESET   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TS_W-1:0]          cur_time,
  input  logic [NUM_TRIG-1:0]      trig_in,
  input  logic [NUM_TRIG-1:0]      trig_fall_sel,
  input  logic                     thr_wr,
  input  logic [THR_W:0]           thr_wdata,
  output logic [NUM_TRIG-1:0]      ts_valid,
  input  logic [NUM_TRIG-1:0]      ts_ready,
  output logic [NUM_TRIG-1:0]      ts_half,
  output logic [NUM_TRIG*HALF_W-1:0] ts_data,
  input  logic [NUM_TRIG-1:0]      ovf_clr,
  input  logic [NUM_TRIG-1:0]      avail_en,
  input  logic [NUM_TRIG-1:0]      thr_en,
  input  logic [NUM_TRIG-1:0]      ovf_en,
  output logic [NUM_TRIG-1:0]      evt_avail,
  output logic [NUM_TRIG-1:0]      evt_thr,
  output logic [NUM_TRIG-1:0]      evt_ovf
);
  logic [THR_W-1:0]    thr_q;
  logic [NUM_TRIG-1:0] edge_hit, thr_hit, ovf_flag;

  // a set top bit means the value exceeds the largest legal threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        thr_q <= THR_W'(THR_RESET);
    else if (thr_wr && !thr_wdata[THR_W]) thr_q <= thr_wdata[THR_W-1:0];
  end

  assert_thr_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && thr_wdata[THR_W]) |=> $stable(thr_q));

  for (genvar c = 0; c < NUM_TRIG; c++) begin : g_chan
    ettc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_async (trig_in[c]),
      .fall_sel   (trig_fall_sel[c]),
      .edge_hit   (edge_hit[c])
    );

    ettc_ts_fifo #(.DEPTH(DEPTH), .THR_W(THR_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (edge_hit[c]),
      .push_ts  (cur_time),
      .rd_ready (ts_ready[c]),
      .ovf_clr  (ovf_clr[c]),
      .thr      (thr_q),
      .rd_valid (ts_valid[c]),
      .rd_half  (ts_half[c]),
      .rd_data  (ts_data[c*HALF_W +: HALF_W]),
      .thr_hit  (thr_hit[c]),
      .ovf_flag (ovf_flag[c])
    );

    assign evt_avail[c] = ts_valid[c] && avail_en[c];
    assign evt_thr[c]   = thr_hit[c]  && thr_en[c];
    assign evt_ovf[c]   = ovf_flag[c] && ovf_en[c];
  end
endmodule

// File: tb/ext_ts_capture_fifo_bench.sv
`timescale 1ns/1ps
module ext_ts_capture_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cur_time = 64'h0123_4567_89AB_CDEF;
  logic [1:0]  trig_in = '0, trig_fall_sel = '0, ts_ready = '0, ovf_clr = '0;
  logic [1:0]  avail_en = '1, thr_en = '1, ovf_en = '1;
  logic        thr_wr = 1'b0;
  logic [4:0]  thr_wdata = '0;
  logic [1:0]  ts_valid, ts_half, evt_avail, evt_thr, evt_ovf;
  logic [63:0] ts_data;

  ext_ts_capture_fifo u_ext_ts_capture_fifo (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .trig_in(trig_in),
    .trig_fall_sel(trig_fall_sel), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .ts_valid(ts_valid), .ts_ready(ts_ready), .ts_half(ts_half), .ts_data(ts_data),
    .ovf_clr(ovf_clr), .avail_en(avail_en), .thr_en(thr_en), .ovf_en(ovf_en),
    .evt_avail(evt_avail), .evt_thr(evt_thr), .evt_ovf(evt_ovf));

  always #2 clk = ~clk;

  // next-cycle stimulus
  logic [1:0] nx_trig = '0, nx_fsel = '0, nx_ready = '0, nx_clr = '0;
  logic [1:0] nx_aen = '1, nx_ten = '1, nx_oen = '1;
  logic       nx_wr = 1'b0;
  logic [4:0] nx_wdata = '0;

  // reference model
  logic [63:0] mq [2][16];
  int          mhead [2], mcnt [2], mthr;
  bit          mhalf [2], movf [2];
  bit          hist [2][4];

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input int c);
    logic [63:0] t = mq[c][mhead[c]];
    return mhalf[c] ? t[63:32] : t[31:0];
  endfunction

  task automatic check_all();
    for (int c = 0; c < 2; c++) begin
      cmp("R5 R12 valid", 64'(ts_valid[c]), 64'(mcnt[c] > 0));
      cmp("R4 half", 64'(ts_half[c]), 64'(mhalf[c]));
      if (mcnt[c] > 0) cmp("R1 R3 R4 data", 64'(ts_data[c*32 +: 32]), 64'(exp_word(c)));
      cmp("R8 R10 thr event", 64'(evt_thr[c]), 64'((mcnt[c] >= mthr) && thr_en[c]));
      cmp("R10 avail event", 64'(evt_avail[c]), 64'((mcnt[c] > 0) && avail_en[c]));
      cmp("R7 R10 ovf event", 64'(evt_ovf[c]), 64'(movf[c] && ovf_en[c]));
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    trig_in = nx_trig; trig_fall_sel = nx_fsel; ts_ready = nx_ready; ovf_clr = nx_clr;
    avail_en = nx_aen; thr_en = nx_ten; ovf_en = nx_oen; thr_wr = nx_wr; thr_wdata = nx_wdata;
    cur_time = cur_time + 64'h0000_0001_0000_0003;
    nx_clr = '0; nx_wr = 1'b0;
    for (int c = 0; c < 2; c++) begin
      bit edge_now, full, had;
      hist[c][3] = hist[c][2]; hist[c][2] = hist[c][1];
      hist[c][1] = hist[c][0]; hist[c][0] = trig_in[c];
      edge_now = trig_fall_sel[c] ? (!hist[c][2] && hist[c][3]) : (hist[c][2] && !hist[c][3]);
      full = (mcnt[c] == 16);
      had  = (mcnt[c] > 0);
      if (edge_now && !full) begin
        mq[c][(mhead[c] + mcnt[c]) % 16] = cur_time;
        mcnt[c]++;
      end
      if (ts_ready[c] && had) begin
        if (!mhalf[c]) mhalf[c] = 1'b1;
        else begin
          mhead[c] = (mhead[c] + 1) % 16; mcnt[c]--; mhalf[c] = 1'b0;
        end
      end
      if (ovf_clr[c]) movf[c] = 1'b0;
      if (edge_now && full) movf[c] = 1'b1;
    end
    if (thr_wr && thr_wdata <= 5'd15) mthr = int'(thr_wdata);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input int c);  // one active edge, idle afterwards
    nx_trig[c] = ~nx_trig[c]; steps(2);
    nx_trig[c] = ~nx_trig[c]; steps(2);
  endtask

  task automatic drain(input int c);
    nx_ready[c] = 1'b1;
    for (int i = 0; i < 40 && mcnt[c] > 0; i++) step();
    nx_ready[c] = 1'b0; step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int c = 0; c < 2; c++) begin
      mhead[c] = 0; mcnt[c] = 0; mhalf[c] = 0; movf[c] = 0;
      for (int k = 0; k < 4; k++) hist[c][k] = 0;
    end
    mthr = 8;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11 reset state
    cmp("R11 valid after reset", 64'(ts_valid), 64'(0));
    cmp("R11 half after reset", 64'(ts_half), 64'(0));
    cmp("R11 ovf after reset", 64'(evt_ovf), 64'(0));
    cmp("R11 thr event after reset", 64'(evt_thr), 64'(0));

    // R6 ready with empty queue
    nx_ready = 2'b11; steps(3); nx_ready = '0; steps(1);
    cmp("R6 valid unchanged", 64'(ts_valid), 64'(0));
    cmp("R6 half unchanged", 64'(ts_half), 64'(0));

    // R1 single capture on pin 0, then read both halves
    pulse(0); steps(2);
    cmp("R1 stamp arrived", 64'(ts_valid[0]), 64'(1));
    drain(0);

    // R2 falling select on pin 1: rising edge ignored, falling edge captured
    nx_fsel[1] = 1'b1; steps(2);
    nx_trig[1] = 1'b1; steps(6);
    cmp("R2 opposite edge ignored", 64'(ts_valid[1]), 64'(0));
    nx_trig[1] = 1'b0; steps(5);
    cmp("R2 selected edge captured", 64'(ts_valid[1]), 64'(1));
    drain(1); nx_fsel[1] = 1'b0; steps(2);

    // R7 fill pin 0 past 16, overflow sticky, then clear and drain in order
    for (int i = 0; i < 17; i++) pulse(0);
    steps(3);
    cmp("R7 overflow flagged", 64'(evt_ovf[0]), 64'(1));
    cmp("R7 pin 1 untouched", 64'(evt_ovf[1]), 64'(0));
    nx_oen[0] = 1'b0; steps(2);
    cmp("R10 ovf event masked", 64'(evt_ovf[0]), 64'(0));
    nx_oen[0] = 1'b1; nx_clr[0] = 1'b1; steps(2);
    cmp("R7 overflow cleared", 64'(evt_ovf[0]), 64'(0));

    // R9 threshold write rejection, seen on the threshold event with 16 queued
    nx_wr = 1'b1; nx_wdata = 5'd15; steps(2);
    cmp("R9 threshold 15 accepted", 64'(evt_thr[0]), 64'(1));
    nx_wr = 1'b1; nx_wdata = 5'd20; steps(2);
    cmp("R9 threshold 20 rejected", 64'(evt_thr[0]), 64'(1));
    drain(0);
    nx_wr = 1'b1; nx_wdata = 5'd3; steps(2);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < 2; c++) begin
        if ($urandom % 4 == 0)  nx_trig[c] = ~nx_trig[c];
        if ($urandom % 97 == 0) nx_fsel[c] = ~nx_fsel[c];
        nx_ready[c] = ($urandom % 5 < ((i / 500) % 2 == 0 ? 1 : 3));
        if ($urandom % 60 == 0) nx_clr[c] = 1'b1;
        if ($urandom % 80 == 0) nx_aen[c] = ~nx_aen[c];
        if ($urandom % 80 == 0) nx_ten[c] = ~nx_ten[c];
        if ($urandom % 80 == 0) nx_oen[c] = ~nx_oen[c];
      end
      if ($urandom % 50 == 0) begin
        nx_wr = 1'b1; nx_wdata = 5'($urandom % 32);
      end
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule